// File: doc/BRIEF.md
# Interval Down-Counter Timer

This block is a 32-bit interval timer that sits behind a plain word-wide register port. A counter steps down by one on each qualifying tick. When it is at zero, the next step either refills it from a programmed interval value or lets it wrap to all-ones and keep falling freely. The counter is compared with a programmable match value. A match latches a sticky event flag, which software clears by writing a one, and which can drive a level interrupt.

Counting is qualified by three things: a run bit, a nonzero clock-source code, and a one-cycle tick enable supplied from outside the block. The block never selects a clock itself. It stores the source code and a few run-option bits so that software can read them back. Software can start an interval in three ways: a refill when the run bit rises, an immediate overwrite when the interval value is written, or resuming from the held count. A self-clearing soft reset returns the block to its idle state over a fixed number of clock cycles.

Top module: `ivt_timer`

## Requirements
- R1: After rst_n is held low, the control, status, interval and match registers read 0, the counter reads 0xFFFFFFFF and irq is 0.
- R2: Byte offsets decode as follows: 0x00 control, 0x04 status, 0x08 interval, 0x0C match, 0x10 counter (read-only). Writes to 0x10 and to undecoded offsets change nothing. Undecoded offsets read 0. Control keeps only bits 0, 1, 2, 3, 17, 18, 19, 21 and 25:24, so writing 0xFFFEFFFF reads back 0x032E000F.
- R3: The counter moves only in a cycle where control bit 0 (run) is 1, control bits 25:24 (source) are nonzero and tick_en is 1. In any other cycle it holds its value.
- R4: A step taken while the counter is 0 loads the interval register when control bit 3 (refill) is 1, and loads 0xFFFFFFFF when bit 3 is 0. Any other step decrements by one.
- R5: When a control write raises run from 0 to 1 with bit 1 (restart) set, the counter becomes the interval value if refill is 1, or 0xFFFFFFFF if refill is 0. With bit 1 clear, counting resumes from the held value. Clearing run stops the counter.
- R6: While control bit 17 (overwrite) is 1, a write to the interval register also loads the written value into the counter at the same edge.
- R7: Status bit 0 (match flag) is set by a step taken while the counter equals the match register. It stays set until a write with bit 0 equal to 1. A write with bit 0 equal to 0 leaves it unchanged. When a match step and a clearing write fall in the same cycle, the flag stays set.
- R8: irq is high exactly while the match flag is set and control bit 2 (interrupt enable) is 1.
- R9: A control write with bit 16 set starts a soft reset, and the other bits of that write are ignored. For SRST_CYCLES cycles, bit 16 reads 1, every other register reads 0, the counter reads 0xFFFFFFFF and all writes are ignored. After that, bit 16 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count-enable pulse from the selected time base |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the accessed register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| irq | output | 1 | Match interrupt, level |

## Verification
The bench sweeps every interval from 2 to 5 against every match value from 0 up to the interval, in refill mode, across more than two full periods. A design that refilled one step late, or skipped zero, would drift from the arithmetic period of interval+1. A design that compared the counter after the step instead of before would raise the flag one step early. The free-run wrap from 0 to 0xFFFFFFFF is checked through a match placed on 0xFFFFFFFE, which catches a design that refills in both modes. The bench also covers:
- a clearing write that lands in the same cycle as a match, where a wrong priority would lose the event;
- restart with bit 1 clear, where a design that always reloads would jump;
- a write issued during soft reset, which a design that leaves writes open would let through.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
// ivt_pkg: register offsets, control bit positions and the stored control
// fields shared by the interval timer modules. Assumes a 32-bit data path.
package ivt_pkg;

    localparam int unsigned OFS_CTRL  = 5'h00;
    localparam int unsigned OFS_STAT  = 5'h04;
    localparam int unsigned OFS_LOAD  = 5'h08;
    localparam int unsigned OFS_MATCH = 5'h0C;
    localparam int unsigned OFS_COUNT = 5'h10;

    localparam int unsigned B_RUN     = 0;
    localparam int unsigned B_RESTART = 1;
    localparam int unsigned B_IRQEN   = 2;
    localparam int unsigned B_REFILL  = 3;
    localparam int unsigned B_SRST    = 16;
    localparam int unsigned B_OVW     = 17;
    localparam int unsigned B_OPT_DBG = 18;
    localparam int unsigned B_OPT_WT  = 19;
    localparam int unsigned B_OPT_STP = 21;
    localparam int unsigned B_SRC_LO  = 24;

    typedef struct packed {
        logic [1:0] src;
        logic       opt_stp;
        logic       opt_wt;
        logic       opt_dbg;
        logic       ovw;
        logic       refill;
        logic       irqen;
        logic       restart;
        logic       run;
    } ctrl_t;

endpackage

// File: rtl/ivt_srst.sv
`timescale 1ns/1ps
// ivt_srst: soft-reset sequencer. A start pulse makes busy high for exactly
// CYCLES clock cycles. Assumes start is only asserted while busy is low.
module ivt_srst #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned BW = $clog2(CYCLES + 1);

    logic [BW-1:0] remain_q;

    // Load the remaining-cycle count on start, then run it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (start) begin
            remain_q <= BW'(CYCLES);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign busy = (remain_q != '0);
endmodule

// File: rtl/ivt_counter.sv
`timescale 1ns/1ps
// ivt_counter: the down-counter datapath. Priority: clear, run-rise restart,
// overwrite load, then tick step. Assumes step is never high together with
// rise_ld (the step needs run already set).
module ivt_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic              rise_ld,
    input  logic              rise_refill,
    input  logic              refill,
    input  logic [DATA_W-1:0] interval,
    input  logic              ovw_ld,
    input  logic [DATA_W-1:0] ovw_val,
    output logic [DATA_W-1:0] count
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] at_zero_val;

    // Choose the value taken by a step from zero.
    always_comb begin
        at_zero_val = refill ? interval : ALL_ONES;
    end

    // Update the count according to the priority order above.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count_q <= ALL_ONES;
        end else if (rise_ld) begin
            count_q <= rise_refill ? interval : ALL_ONES;
        end else if (ovw_ld) begin
            count_q <= ovw_val;
        end else if (step) begin
            count_q <= (count_q == '0) ? at_zero_val : count_q - 1'b1;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/ivt_matchflag.sv
`timescale 1ns/1ps
// ivt_matchflag: sticky match flag with write-one-to-clear. A match event
// wins over a clearing write in the same cycle; clr wins over both.
module ivt_matchflag (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic hit,
    input  logic wipe,
    output logic flag
);
    logic flag_q;

    // Set on hit, clear on wipe unless hit, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (wipe) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/ivt_timer.sv
`timescale 1ns/1ps
// ivt_timer: register-mapped interval down-counter with match flag, level
// interrupt and self-clearing soft reset. Assumes tick_en is a one-cycle
// qualified pulse in the clk domain and DATA_W is at least 26.
module ivt_timer #(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned SRST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    import ivt_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFS_LOAD);
    localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(OFS_MATCH);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);

    ctrl_t             ctrl_q;
    ctrl_t             ctrl_d;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] match_q;
    logic [DATA_W-1:0] cnt_q;
    logic              flag_q;
    logic              srst_busy;
    logic              srst_start;
    logic              clr_all;
    logic              wr_ok;
    logic              wr_ctrl;
    logic              wr_stat;
    logic              wr_load;
    logic              wr_match;
    logic              run_rise;
    logic              step;
    logic              hit;
    logic [DATA_W-1:0] ctrl_rd;

    // Decode a write to each register; all writes are blocked during soft reset.
    always_comb begin
        wr_ok      = reg_wr && !srst_busy;
        wr_ctrl    = wr_ok && (reg_addr == A_CTRL);
        wr_stat    = wr_ok && (reg_addr == A_STAT);
        wr_load    = wr_ok && (reg_addr == A_LOAD);
        wr_match   = wr_ok && (reg_addr == A_MATCH);
        srst_start = wr_ctrl && reg_wdata[B_SRST];
        clr_all    = srst_start || srst_busy;
    end

    // Unpack the stored control fields from the write data.
    always_comb begin
        ctrl_d.src     = reg_wdata[B_SRC_LO +: 2];
        ctrl_d.opt_stp = reg_wdata[B_OPT_STP];
        ctrl_d.opt_wt  = reg_wdata[B_OPT_WT];
        ctrl_d.opt_dbg = reg_wdata[B_OPT_DBG];
        ctrl_d.ovw     = reg_wdata[B_OVW];
        ctrl_d.refill  = reg_wdata[B_REFILL];
        ctrl_d.irqen   = reg_wdata[B_IRQEN];
        ctrl_d.restart = reg_wdata[B_RESTART];
        ctrl_d.run     = reg_wdata[B_RUN];
    end

    // Hold the control register; cleared by hard or soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_d;
        end
    end

    // Hold the interval and match registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            load_q  <= '0;
            match_q <= '0;
        end else begin
            if (wr_load) begin
                load_q <= reg_wdata;
            end
            if (wr_match) begin
                match_q <= reg_wdata;
            end
        end
    end

    // Qualify the count step and the match event.
    always_comb begin
        run_rise = wr_ctrl && !srst_start && ctrl_d.run && !ctrl_q.run
                   && ctrl_d.restart;
        step     = ctrl_q.run && (ctrl_q.src != 2'b00) && tick_en;
        hit      = step && (cnt_q == match_q);
    end

    ivt_srst #(
        .CYCLES (SRST_CYCLES)
    ) srst_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (srst_start),
        .busy  (srst_busy)
    );

    ivt_counter #(
        .DATA_W (DATA_W)
    ) counter_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr_all),
        .step        (step),
        .rise_ld     (run_rise),
        .rise_refill (ctrl_d.refill),
        .refill      (ctrl_q.refill),
        .interval    (load_q),
        .ovw_ld      (wr_load && ctrl_q.ovw),
        .ovw_val     (reg_wdata),
        .count       (cnt_q)
    );

    ivt_matchflag flag_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_all),
        .hit   (hit),
        .wipe  (wr_stat && reg_wdata[0]),
        .flag  (flag_q)
    );

    // Rebuild the control read image, soft-reset bit from the sequencer.
    always_comb begin
        ctrl_rd                   = '0;
        ctrl_rd[B_RUN]            = ctrl_q.run;
        ctrl_rd[B_RESTART]        = ctrl_q.restart;
        ctrl_rd[B_IRQEN]          = ctrl_q.irqen;
        ctrl_rd[B_REFILL]         = ctrl_q.refill;
        ctrl_rd[B_SRST]           = srst_busy;
        ctrl_rd[B_OVW]            = ctrl_q.ovw;
        ctrl_rd[B_OPT_DBG]        = ctrl_q.opt_dbg;
        ctrl_rd[B_OPT_WT]         = ctrl_q.opt_wt;
        ctrl_rd[B_OPT_STP]        = ctrl_q.opt_stp;
        ctrl_rd[B_SRC_LO +: 2]    = ctrl_q.src;
    end

    // Select the read data by offset.
    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = ctrl_rd;
            A_STAT:  reg_rdata = {{(DATA_W-1){1'b0}}, flag_q};
            A_LOAD:  reg_rdata = load_q;
            A_MATCH: reg_rdata = match_q;
            A_COUNT: reg_rdata = cnt_q;
            default: reg_rdata = '0;
        endcase
    end

    assign irq = flag_q && ctrl_q.irqen;
endmodule

// File: rtl/ivt_timer_chk.sv
`timescale 1ns/1ps
// ivt_timer_chk: temporal properties of the interval timer, bound to it.
module ivt_timer_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              reg_wr,
    input logic              step,
    input logic              refill,
    input logic              busy,
    input logic              flag,
    input logic              irq,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] match
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !reg_wr && !busy) |=> $stable(cnt)); // R3

    AST_DECREMENT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !reg_wr && !busy && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R4

    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !reg_wr && !busy && cnt == '0 && !refill) |=> (cnt == ALL_ONES)); // R4

    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !busy && cnt == match && !reg_wr) |=> flag); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !reg_wr) |=> flag); // R7

    AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt == ALL_ONES && !irq && !flag)); // R9
endmodule

bind ivt_timer ivt_timer_chk #(
    .DATA_W (DATA_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .reg_wr  (reg_wr),
    .step    (step),
    .refill  (ctrl_q.refill),
    .busy    (srst_busy),
    .flag    (flag_q),
    .irq     (irq),
    .cnt     (cnt_q),
    .match   (match_q)
);

// File: tb/ivt_timer_tb.sv
`timescale 1ns/1ps
module ivt_timer_tb_top;
    localparam logic [4:0] A_CTRL  = 5'h00;
    localparam logic [4:0] A_STAT  = 5'h04;
    localparam logic [4:0] A_LOAD  = 5'h08;
    localparam logic [4:0] A_MATCH = 5'h0C;
    localparam logic [4:0] A_COUNT = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_cnt, m_load, m_cmp;
    logic        m_flag, m_rld;

    always #10 clk = ~clk;

    ivt_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic mstep();
        if (m_cnt == m_cmp) m_flag = 1'b1;
        m_cnt = (m_cnt == 32'd0) ? (m_rld ? m_load : 32'hFFFF_FFFF) : m_cnt - 32'd1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h0);
        rd(A_STAT, v);  chk("R1 status", v, 32'h0);
        rd(A_LOAD, v);  chk("R1 interval", v, 32'h0);
        rd(A_MATCH, v); chk("R1 match", v, 32'h0);
        rd(A_COUNT, v); chk("R1 counter", v, 32'hFFFF_FFFF);
        chk("R1 irq", {31'd0, irq}, 32'h0);

        // R2: register map and stored control bits
        wr(A_CTRL, 32'hFFFE_FFFF);
        rd(A_CTRL, v);  chk("R2 ctrl mask", v, 32'h032E_000F);
        wr(A_CTRL, 32'h0);
        wr(A_LOAD, 32'hA5A5_0000);
        rd(A_LOAD, v);  chk("R2 interval rw", v, 32'hA5A5_0000);
        wr(A_MATCH, 32'h0000_1234);
        rd(A_MATCH, v); chk("R2 match rw", v, 32'h0000_1234);
        wr(A_COUNT, 32'h55);
        rd(A_COUNT, v); chk("R2 counter read-only", v, 32'h0);
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h14, v);   chk("R2 undecoded offset", v, 32'h0);

        // R4 R5 R7 R8: sweep intervals and match values in refill mode
        for (int L = 2; L <= 5; L++) begin
            for (int C = 0; C <= L; C++) begin
                wr(A_STAT, 32'h1);
                wr(A_LOAD, 32'(L));
                wr(A_MATCH, 32'(C));
                wr(A_CTRL, 32'h0100_000F);
                m_cnt = 32'(L); m_load = 32'(L); m_cmp = 32'(C);
                m_flag = 1'b0; m_rld = 1'b1;
                rd(A_COUNT, v); chk("R5 restart loads interval", v, m_cnt);
                for (int n = 0; n < 2 * L + 4; n++) begin
                    tick();
                    mstep();
                    rd(A_COUNT, v); chk("R4 refill count", v, m_cnt);
                    rd(A_STAT, v);  chk("R7 match flag", v, {31'd0, m_flag});
                    chk("R8 irq", {31'd0, irq}, {31'd0, m_flag});
                end
                wr(A_CTRL, 32'h0);
            end
        end

        // R6 R5 R4: overwrite load, resume, free-run wrap
        wr(A_CTRL, 32'h0002_0000);
        wr(A_MATCH, 32'hFFFF_FFFE);
        wr(A_STAT, 32'h1);
        wr(A_LOAD, 32'd3);
        rd(A_COUNT, v); chk("R6 overwrite while stopped", v, 32'd3);
        wr(A_CTRL, 32'h0202_0005);
        rd(A_COUNT, v); chk("R5 resume without restart", v, 32'd3);
        m_cnt = 32'd3; m_load = 32'd3; m_cmp = 32'hFFFF_FFFE; m_flag = 1'b0; m_rld = 1'b0;
        for (int n = 0; n < 6; n++) begin
            tick();
            mstep();
            rd(A_COUNT, v); chk("R4 free-run wrap", v, m_cnt);
            rd(A_STAT, v);  chk("R7 flag at wrap", v, {31'd0, m_flag});
        end
        chk("R8 irq on", {31'd0, irq}, 32'h1);
        wr(A_LOAD, 32'd100);
        rd(A_COUNT, v); chk("R6 overwrite while running", v, 32'd100);

        // R3: gating by source code and run bit
        wr(A_CTRL, 32'h0000_0005);
        tick(); tick();
        rd(A_COUNT, v); chk("R3 source off holds", v, 32'd100);
        wr(A_CTRL, 32'h0100_0000);
        tick(); tick();
        rd(A_COUNT, v); chk("R3 run off holds", v, 32'd100);
        wr(A_CTRL, 32'h0100_0001);
        rd(A_COUNT, v); chk("R5 resume held value", v, 32'd100);
        @(negedge clk);
        rd(A_COUNT, v); chk("R3 no tick holds", v, 32'd100);
        tick();
        rd(A_COUNT, v); chk("R3 step decrements", v, 32'd99);

        // R7 R8: clear semantics
        rd(A_STAT, v);  chk("R7 flag still set", v, 32'h1);
        chk("R8 irq masked", {31'd0, irq}, 32'h0);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v);  chk("R7 write zero keeps flag", v, 32'h1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v);  chk("R7 write one clears", v, 32'h0);
        wr(A_MATCH, 32'd98);
        tick();
        rd(A_STAT, v);  chk("R7 no early match", v, 32'h0);
        tick();
        rd(A_STAT, v);  chk("R7 match sets", v, 32'h1);
        wr(A_MATCH, 32'd97);
        @(negedge clk);
        tick_en = 1'b1; reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h1;
        @(negedge clk);
        tick_en = 1'b0; reg_wr = 1'b0;
        rd(A_STAT, v);  chk("R7 match beats clear", v, 32'h1);
        rd(A_COUNT, v); chk("R7 counter stepped", v, 32'd96);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v);  chk("R7 clear alone", v, 32'h0);

        // R9: soft reset
        wr(A_LOAD, 32'd9);
        wr(A_CTRL, 32'h0001_0005);
        rd(A_CTRL, v);  chk("R9 busy bit", v, 32'h0001_0000);
        rd(A_LOAD, v);  chk("R9 interval cleared", v, 32'h0);
        rd(A_COUNT, v); chk("R9 counter all ones", v, 32'hFFFF_FFFF);
        chk("R9 irq low", {31'd0, irq}, 32'h0);
        wr(A_LOAD, 32'd7);
        begin
            int polls;
            polls = 0;
            rd(A_CTRL, v);
            while (v[16] && polls < 20) begin
                @(negedge clk);
                polls++;
                rd(A_CTRL, v);
            end
            chk("R9 bit self-clears", v, 32'h0);
            chk("R9 duration bounded", {31'd0, polls <= 4}, 32'h1);
        end
        rd(A_LOAD, v);  chk("R9 write ignored while busy", v, 32'h0);
        rd(A_COUNT, v); chk("R9 counter after reset", v, 32'hFFFF_FFFF);
        wr(A_LOAD, 32'd7);
        rd(A_LOAD, v);  chk("R9 writes accepted after", v, 32'd7);

        summary();
        $finish;
    end
endmodule